// File: doc/BRIEF.md
# Power Button Controller with Debounce

The block takes the raw signal from a power push-button and conditions it for the rest of the chip. The input passes through a synchronizer and a debouncer driven by a millisecond tick. The clean level then feeds two consumers. The first is an interrupt detector that latches a flag on a level or on an edge of the button. The second is a power sequencer that holds a power-on request for the external supply. The sequencer asserts the request after a press of programmable length while the system is off. It drops the request and reports an emergency shutdown when the button is held past a programmable long-press limit.

Configuration comes from a 12-bit control word written with a one-cycle strobe. Status flags are cleared by writing ones through a separate clear strobe. Each of the durations is picked from a fixed set of four codes, so software selects a time class rather than an exact count. All timers advance only on cycles where the millisecond tick is high.

Top module: `pwr_button_ctrl`

## Requirements
- R1: After reset the request and all flags are low and `btn_level` shows the idle level 1. The control word resets to zero, which means active-low interrupt mode, interrupt masked, 50 ms debounce, on-request disabled and no override.
- R2: `btn_level` takes the synchronized input value only after that value has differed from it for the selected number of ticks. Debounce code (control bits [5:4]) 0 selects 50, 1 selects 100, 2 selects 500, and 3 selects none. A shorter excursion leaves the level unchanged.
- R3: Debounce and press timers advance only on cycles with `ms_tick` high. While the tick is low, a pending input change never reaches `btn_level`.
- R4: Interrupt mode (control bits [2:0]) sets the latched flag as follows: 0 while the level is low, 1 while it is high, 2 on a rising edge, 3 on a falling edge, 4 on either edge. Codes 5 to 7 never set the flag.
- R5: `irq` is the latched flag gated by the interrupt enable in control bit [3]. The flag latches whether or not the interrupt is enabled.
- R6: Each of the three flags stays set until a clear strobe carries a one in its bit: [0] for the interrupt flag, [1] for emergency-off, [2] for set-power-off. If a set condition and a clear arrive in the same cycle, the flag stays set.
- R7: While the request is low and on-request enable (control bit [10]) is 1, a press held for the on-time asserts `pwr_on_req` in the tick after the hold reaches that value. On-time code (bits [7:6]) 0 selects 500 ms, 1 selects 50, 2 selects 100, and 3 selects 0. With the enable at 0, no press asserts it.
- R8: Override (control bit [11]) forces `pwr_on_req` high from the cycle after the write, whatever the button does.
- R9: While on, a press held for the long-press limit clears the internal request and sets `emerg_off`. Press-timeout code (bits [9:8]) 0 selects 5 s, 1 selects 10 s, 2 selects 15 s, and 3 disables this shutdown. The press that caused it cannot turn the system back on.
- R10: The release of a press that began while on, and did not itself turn the system on or off, sets `set_pwr_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond; timers advance only on it |
| btn_in | input | 1 | Raw button input; low means pressed |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 12 | Control word: [2:0] mode, [3] irq enable, [5:4] debounce, [7:6] on-time, [9:8] press timeout, [10] on-request enable, [11] override |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 3 | Write-one-to-clear mask: [0] interrupt flag, [1] emergency-off, [2] set-power-off |
| btn_level | output | 1 | Debounced button level |
| btn_irq_flag | output | 1 | Latched button interrupt flag |
| irq | output | 1 | Interrupt request, flag gated by enable |
| emerg_off | output | 1 | Long-press shutdown flag |
| set_pwr_off | output | 1 | Short-press-while-on flag |
| pwr_on_req | output | 1 | Power-on request to the supply |

## Verification
The interrupt flag can receive a software clear and a new set condition in the same cycle. The bench provokes this in active-high level mode: the idle button level keeps the flag set on every cycle while a clear strobe is issued. The flag must read 1 after the strobe, because set takes priority over clear. The bench also checks the opposite case, a clear with no competing set, which must leave the flag at 0. The long-press shutdown and the override write are also exercised close together, and the request is judged against the override state.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int CTL_W = 12;
    localparam int STS_W = 3;

    localparam int STS_FLAG = 0;
    localparam int STS_EO   = 1;
    localparam int STS_SPO  = 2;

    localparam logic [2:0] MODE_LOW  = 3'd0;
    localparam logic [2:0] MODE_HIGH = 3'd1;
    localparam logic [2:0] MODE_RISE = 3'd2;
    localparam logic [2:0] MODE_FALL = 3'd3;
    localparam logic [2:0] MODE_ANY  = 3'd4;

    typedef struct packed {
        logic       ovr;
        logic       req_en;
        logic [1:0] tmo_sel;
        logic [1:0] on_sel;
        logic [1:0] deb_sel;
        logic       irq_en;
        logic [2:0] mode;
    } pbc_ctl_t;

    localparam pbc_ctl_t CTL_RESET = '0;

endpackage

// File: rtl/pbc_debounce.sv
module pbc_debounce #(
    parameter int   SYNC_STAGES = 2,
    parameter int   DB_MS_0     = 50,
    parameter int   DB_MS_1     = 100,
    parameter int   DB_MS_2     = 500,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       raw_i,
    input  logic [1:0] sel_i,
    output logic       level_o
);

    localparam int DB_MAX = (DB_MS_0 > DB_MS_1) ?
                            ((DB_MS_0 > DB_MS_2) ? DB_MS_0 : DB_MS_2) :
                            ((DB_MS_1 > DB_MS_2) ? DB_MS_1 : DB_MS_2);
    localparam int CW = $clog2(DB_MAX + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   lvl;
        logic [CW-1:0]          cnt;
    } db_state_t;

    db_state_t q, d;
    logic [SYNC_STAGES-1:0] sync_next;
    logic [CW-1:0]          lim;
    logic                   stable;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            assign sync_next = raw_i;
        end else begin : g_chain
            assign sync_next = {q.sync[SYNC_STAGES-2:0], raw_i};
        end
    endgenerate

    always_comb begin
        unique case (sel_i)
            2'd0:    lim = CW'(DB_MS_0);
            2'd1:    lim = CW'(DB_MS_1);
            2'd2:    lim = CW'(DB_MS_2);
            default: lim = '0;
        endcase
    end

    assign stable = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = sync_next;
        if (stable == q.lvl) begin
            d.cnt = '0;
        end else if (lim == '0) begin
            d.lvl = stable;
            d.cnt = '0;
        end else if (ms_tick) begin
            if (q.cnt == lim - CW'(1)) begin
                d.lvl = stable;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= {SYNC_STAGES{IDLE_LEVEL}};
            q.lvl  <= IDLE_LEVEL;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.lvl;

endmodule

// File: rtl/pbc_irq_detect.sv
module pbc_irq_detect
    import pbc_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic [2:0] mode_i,
    input  logic       clr_i,
    output logic       flag_o
);

    typedef struct packed {
        logic lvl_prev;
        logic flag;
    } irq_state_t;

    irq_state_t q, d;
    logic rise, fall, hit;

    assign rise = level_i & ~q.lvl_prev;
    assign fall = ~level_i & q.lvl_prev;

    always_comb begin
        case (mode_i)
            MODE_LOW:  hit = ~level_i;
            MODE_HIGH: hit = level_i;
            MODE_RISE: hit = rise;
            MODE_FALL: hit = fall;
            MODE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_comb begin
        d          = q;
        d.lvl_prev = level_i;
        d.flag     = hit | (q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lvl_prev <= IDLE_LEVEL;
            q.flag     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign flag_o = q.flag;

endmodule

// File: rtl/pbc_power_seq.sv
module pbc_power_seq #(
    parameter int   ON_MS_0   = 500,
    parameter int   ON_MS_1   = 50,
    parameter int   ON_MS_2   = 100,
    parameter int   LP_S_0    = 5,
    parameter int   LP_S_1    = 10,
    parameter int   LP_S_2    = 15,
    parameter int   SEC_MS    = 1000,
    parameter logic PRESS_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       level_i,
    input  logic [1:0] on_sel_i,
    input  logic [1:0] tmo_sel_i,
    input  logic       req_en_i,
    input  logic       ovr_i,
    input  logic       clr_eo_i,
    input  logic       clr_spo_i,
    output logic       pwr_req_o,
    output logic       eo_o,
    output logic       spo_o
);

    localparam int LP_MAX_S = (LP_S_0 > LP_S_1) ?
                              ((LP_S_0 > LP_S_2) ? LP_S_0 : LP_S_2) :
                              ((LP_S_1 > LP_S_2) ? LP_S_1 : LP_S_2);
    localparam int ON_MAX   = (ON_MS_0 > ON_MS_1) ?
                              ((ON_MS_0 > ON_MS_2) ? ON_MS_0 : ON_MS_2) :
                              ((ON_MS_1 > ON_MS_2) ? ON_MS_1 : ON_MS_2);
    localparam int LP_MAX   = LP_MAX_S * SEC_MS;
    localparam int HOLD_MAX = (LP_MAX > ON_MAX) ? LP_MAX : ON_MAX;
    localparam int HW       = $clog2(HOLD_MAX + 1);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic          on;
        logic          wait_rel;
        logic          prev_pressed;
        logic          eo;
        logic          spo;
    } pwr_state_t;

    pwr_state_t q, d;
    logic [HW-1:0] on_lim, lp_lim;
    logic          lp_dis, pressed, eo_set, spo_set;

    assign pressed = PRESS_LOW ? ~level_i : level_i;

    always_comb begin
        unique case (on_sel_i)
            2'd0:    on_lim = HW'(ON_MS_0);
            2'd1:    on_lim = HW'(ON_MS_1);
            2'd2:    on_lim = HW'(ON_MS_2);
            default: on_lim = '0;
        endcase
        lp_dis = 1'b0;
        unique case (tmo_sel_i)
            2'd0:    lp_lim = HW'(LP_S_0 * SEC_MS);
            2'd1:    lp_lim = HW'(LP_S_1 * SEC_MS);
            2'd2:    lp_lim = HW'(LP_S_2 * SEC_MS);
            default: begin
                lp_lim = '1;
                lp_dis = 1'b1;
            end
        endcase
    end

    always_comb begin
        d              = q;
        eo_set         = 1'b0;
        spo_set        = 1'b0;
        d.prev_pressed = pressed;
        if (!pressed) begin
            d.hold     = '0;
            d.wait_rel = 1'b0;
        end else if (ms_tick && (q.hold != '1)) begin
            d.hold = q.hold + HW'(1);
        end
        if (q.on) begin
            if (pressed && !lp_dis && (q.hold >= lp_lim)) begin
                d.on       = 1'b0;
                d.wait_rel = 1'b1;
                eo_set     = 1'b1;
            end else if (!pressed && q.prev_pressed && !q.wait_rel) begin
                spo_set = 1'b1;
            end
        end else if (req_en_i && pressed && !q.wait_rel && (q.hold >= on_lim)) begin
            d.on       = 1'b1;
            d.wait_rel = 1'b1;
        end
        d.eo  = eo_set  | (q.eo  & ~clr_eo_i);
        d.spo = spo_set | (q.spo & ~clr_spo_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pwr_req_o = q.on | ovr_i;
    assign eo_o      = q.eo;
    assign spo_o     = q.spo;

endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl
    import pbc_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter int   DB_MS_0     = 50,
    parameter int   DB_MS_1     = 100,
    parameter int   DB_MS_2     = 500,
    parameter int   ON_MS_0     = 500,
    parameter int   ON_MS_1     = 50,
    parameter int   ON_MS_2     = 100,
    parameter int   LP_S_0      = 5,
    parameter int   LP_S_1      = 10,
    parameter int   LP_S_2      = 15,
    parameter int   SEC_MS      = 1000,
    parameter logic PRESS_LOW   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             btn_in,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             sts_clr_we,
    input  logic [STS_W-1:0] sts_clr,
    output logic             btn_level,
    output logic             btn_irq_flag,
    output logic             irq,
    output logic             emerg_off,
    output logic             set_pwr_off,
    output logic             pwr_on_req
);

    localparam logic IDLE_LEVEL = PRESS_LOW;

    pbc_ctl_t         ctl_d, ctl_q;
    logic [STS_W-1:0] clr;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we) begin
            ctl_d = pbc_ctl_t'(ctl_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign clr = sts_clr_we ? sts_clr : '0;

    pbc_debounce #(
        .SYNC_STAGES (SYNC_STAGES),
        .DB_MS_0     (DB_MS_0),
        .DB_MS_1     (DB_MS_1),
        .DB_MS_2     (DB_MS_2),
        .IDLE_LEVEL  (IDLE_LEVEL)
    ) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .raw_i   (btn_in),
        .sel_i   (ctl_q.deb_sel),
        .level_o (btn_level)
    );

    pbc_irq_detect #(
        .IDLE_LEVEL (IDLE_LEVEL)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (btn_level),
        .mode_i  (ctl_q.mode),
        .clr_i   (clr[STS_FLAG]),
        .flag_o  (btn_irq_flag)
    );

    pbc_power_seq #(
        .ON_MS_0   (ON_MS_0),
        .ON_MS_1   (ON_MS_1),
        .ON_MS_2   (ON_MS_2),
        .LP_S_0    (LP_S_0),
        .LP_S_1    (LP_S_1),
        .LP_S_2    (LP_S_2),
        .SEC_MS    (SEC_MS),
        .PRESS_LOW (PRESS_LOW)
    ) u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .level_i   (btn_level),
        .on_sel_i  (ctl_q.on_sel),
        .tmo_sel_i (ctl_q.tmo_sel),
        .req_en_i  (ctl_q.req_en),
        .ovr_i     (ctl_q.ovr),
        .clr_eo_i  (clr[STS_EO]),
        .clr_spo_i (clr[STS_SPO]),
        .pwr_req_o (pwr_on_req),
        .eo_o      (emerg_off),
        .spo_o     (set_pwr_off)
    );

    assign irq = btn_irq_flag & ctl_q.irq_en;

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ms_tick,
    input logic       ovr_wr,
    input logic       clr_flag,
    input logic       ctl_ovr,
    input logic       ctl_req_en,
    input logic [1:0] deb_sel,
    input logic       btn_level,
    input logic       btn_irq_flag,
    input logic       irq,
    input logic       emerg_off,
    input logic       set_pwr_off,
    input logic       pwr_on_req
);

    // R3: a timed level change needs a tick in the updating cycle
    p_level_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((btn_level != $past(btn_level)) && ($past(deb_sel) != 2'd3)) |-> $past(ms_tick));

    // R5: interrupt output never without the latched flag
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> btn_irq_flag);

    // R6: flag survives any cycle without a clear
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(btn_irq_flag) && !$past(clr_flag)) |-> btn_irq_flag);

    // R7: a press-driven wake needs the enable
    p_wake_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_on_req) && !ctl_ovr) |-> $past(ctl_req_en));

    // R8: writing the override raises the request next cycle
    p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovr_wr) |-> pwr_on_req);

    // R9: emergency shutdown drops the request unless overridden
    p_emerg_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(emerg_off) && !ctl_ovr) |-> !pwr_on_req);

    // R10: set-power-off only arises while the system was on
    p_spo_when_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(set_pwr_off) |-> $past(pwr_on_req));

endmodule

bind pwr_button_ctrl pbc_checker u_pbc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick      (ms_tick),
    .ovr_wr       (ctl_we & ctl_wdata[11]),
    .clr_flag     (sts_clr_we & sts_clr[0]),
    .ctl_ovr      (ctl_q.ovr),
    .ctl_req_en   (ctl_q.req_en),
    .deb_sel      (ctl_q.deb_sel),
    .btn_level    (btn_level),
    .btn_irq_flag (btn_irq_flag),
    .irq          (irq),
    .emerg_off    (emerg_off),
    .set_pwr_off  (set_pwr_off),
    .pwr_on_req   (pwr_on_req)
);

// File: tb/test_pwr_button_ctrl.sv
module test_pwr_button_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b1;
    logic        btn_in = 1'b1;
    logic        ctl_we = 1'b0;
    logic [11:0] ctl_wdata = '0;
    logic        sts_clr_we = 1'b0;
    logic [2:0]  sts_clr = '0;
    logic        btn_level, btn_irq_flag, irq, emerg_off, set_pwr_off, pwr_on_req;

    int n_checks = 0;
    int n_fails  = 0;

    // observed vector: [0] level [1] flag [2] irq [3] eo [4] spo [5] req
    localparam logic [5:0] M_LVL = 6'b000001;
    localparam logic [5:0] M_FLG = 6'b000010;
    localparam logic [5:0] M_IRQ = 6'b000100;
    localparam logic [5:0] M_EO  = 6'b001000;
    localparam logic [5:0] M_SPO = 6'b010000;
    localparam logic [5:0] M_REQ = 6'b100000;

    typedef struct {
        string      tag;
        logic [5:0] mask;
        logic [5:0] exp;
    } sb_item_t;

    sb_item_t sbq[$];
    event     smp;

    always #4 clk = ~clk;

    pwr_button_ctrl i_pwr_button_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .btn_in       (btn_in),
        .ctl_we       (ctl_we),
        .ctl_wdata    (ctl_wdata),
        .sts_clr_we   (sts_clr_we),
        .sts_clr      (sts_clr),
        .btn_level    (btn_level),
        .btn_irq_flag (btn_irq_flag),
        .irq          (irq),
        .emerg_off    (emerg_off),
        .set_pwr_off  (set_pwr_off),
        .pwr_on_req   (pwr_on_req)
    );

    function automatic void compare_item(sb_item_t it);
        logic [5:0] obs;
        obs = {pwr_on_req, set_pwr_off, emerg_off, irq, btn_irq_flag, btn_level};
        n_checks++;
        if ((obs & it.mask) !== (it.exp & it.mask)) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b (mask %b) at %0t",
                     it.tag, obs & it.mask, it.exp & it.mask, it.mask, $time);
        end
    endfunction

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(smp);
            while (sbq.size() > 0) begin
                compare_item(sbq.pop_front());
            end
        end
    end

    task automatic expect_out(input string tag, input logic [5:0] mask, input logic [5:0] val);
        sb_item_t it;
        it.tag  = tag;
        it.mask = mask;
        it.exp  = val;
        sbq.push_back(it);
        -> smp;
        #0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(input logic [2:0] mode, input logic ie, input logic [1:0] deb,
                             input logic [1:0] on_t, input logic [1:0] tmo,
                             input logic en, input logic ovr);
        @(negedge clk);
        ctl_we    = 1'b1;
        ctl_wdata = {ovr, en, tmo, on_t, deb, ie, mode};
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic clear_sts(input logic [2:0] bits);
        @(negedge clk);
        sts_clr_we = 1'b1;
        sts_clr    = bits;
        @(negedge clk);
        sts_clr_we = 1'b0;
        sts_clr    = '0;
    endtask

    task automatic finish_run;
        #1;
        while (sbq.size() > 0) compare_item(sbq.pop_front());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        expect_out("R1 reset outputs", 6'b111111, 6'b000001);

        // R2: default debounce 50 ticks, press
        btn_in = 1'b0;
        wait_n(51);
        expect_out("R2 level before 50 ticks", M_LVL, 6'b000000 | M_LVL);
        wait_n(1);
        expect_out("R2 level after 50 ticks", M_LVL, 6'b000000);
        wait_n(5);
        expect_out("R1 default active-low, masked", M_FLG | M_IRQ, M_FLG);
        btn_in = 1'b1;
        wait_n(51);
        expect_out("R2 release before 50", M_LVL, 6'b000000);
        wait_n(1);
        expect_out("R2 release after 50", M_LVL, M_LVL);

        // R2: glitch shorter than debounce
        btn_in = 1'b0;
        wait_n(40);
        btn_in = 1'b1;
        wait_n(100);
        expect_out("R2 short glitch ignored", M_LVL, M_LVL);

        // R2: code 1 = 100
        write_ctl(3'd0, 1'b0, 2'd1, 2'd0, 2'd3, 1'b0, 1'b0);
        btn_in = 1'b0;
        wait_n(101);
        expect_out("R2 code1 before", M_LVL, M_LVL);
        wait_n(1);
        expect_out("R2 code1 after", M_LVL, 6'b000000);
        btn_in = 1'b1;
        wait_n(150);

        // R2: code 2 = 500
        write_ctl(3'd0, 1'b0, 2'd2, 2'd0, 2'd3, 1'b0, 1'b0);
        btn_in = 1'b0;
        wait_n(501);
        expect_out("R2 code2 before", M_LVL, M_LVL);
        wait_n(1);
        expect_out("R2 code2 after", M_LVL, 6'b000000);
        btn_in = 1'b1;
        wait_n(600);

        // R3: no tick, no progress
        write_ctl(3'd0, 1'b0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0);
        ms_tick = 1'b0;
        btn_in  = 1'b0;
        wait_n(200);
        expect_out("R3 tick low holds level", M_LVL, M_LVL);
        ms_tick = 1'b1;
        wait_n(49);
        expect_out("R3 49 ticks", M_LVL, M_LVL);
        wait_n(1);
        expect_out("R3 50 ticks", M_LVL, 6'b000000);
        btn_in = 1'b1;
        wait_n(60);

        // R4/R5/R6 interrupt modes, no debounce
        write_ctl(3'd0, 1'b1, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
        clear_sts(3'b111);
        wait_n(3);
        expect_out("R4 mode0 idle no flag", M_FLG | M_IRQ, 6'b000000);
        btn_in = 1'b0;
        wait_n(6);
        expect_out("R4 mode0 low sets flag, R5 irq", M_FLG | M_IRQ, M_FLG | M_IRQ);
        btn_in = 1'b1;
        wait_n(6);
        clear_sts(3'b001);
        expect_out("R6 clear without set", M_FLG, 6'b000000);

        write_ctl(3'd2, 1'b1, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
        clear_sts(3'b001);
        btn_in = 1'b0;
        wait_n(8);
        expect_out("R4 mode2 falling ignored", M_FLG, 6'b000000);
        btn_in = 1'b1;
        wait_n(6);
        expect_out("R4 mode2 rising sets", M_FLG, M_FLG);

        write_ctl(3'd3, 1'b1, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
        clear_sts(3'b001);
        btn_in = 1'b0;
        wait_n(6);
        expect_out("R4 mode3 falling sets", M_FLG, M_FLG);
        clear_sts(3'b001);
        btn_in = 1'b1;
        wait_n(8);
        expect_out("R4 mode3 rising ignored", M_FLG, 6'b000000);

        write_ctl(3'd4, 1'b1, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
        clear_sts(3'b001);
        btn_in = 1'b0;
        wait_n(6);
        expect_out("R4 mode4 falling sets", M_FLG, M_FLG);
        clear_sts(3'b001);
        expect_out("R6 mode4 cleared", M_FLG, 6'b000000);
        btn_in = 1'b1;
        wait_n(6);
        expect_out("R4 mode4 rising sets", M_FLG, M_FLG);

        write_ctl(3'd1, 1'b1, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
        clear_sts(3'b001);
        expect_out("R6 set wins over clear (mode1 high)", M_FLG, M_FLG);

        write_ctl(3'd5, 1'b1, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
        clear_sts(3'b001);
        btn_in = 1'b0;
        wait_n(6);
        btn_in = 1'b1;
        wait_n(6);
        expect_out("R4 mode5 never sets", M_FLG, 6'b000000);

        write_ctl(3'd0, 1'b0, 2'd3, 2'd0, 2'd3, 1'b0, 1'b0);
        clear_sts(3'b001);
        btn_in = 1'b0;
        wait_n(6);
        expect_out("R5 masked: flag without irq", M_FLG | M_IRQ, M_FLG);
        btn_in = 1'b1;
        wait_n(6);

        // R7/R9 power-on then long press at 5 s
        write_ctl(3'd4, 1'b0, 2'd3, 2'd1, 2'd0, 1'b1, 1'b0);
        clear_sts(3'b111);
        btn_in = 1'b0;
        wait_n(53);
        expect_out("R7 on-time 50 not yet", M_REQ, 6'b000000);
        wait_n(1);
        expect_out("R7 on-time 50 reached", M_REQ, M_REQ);
        wait_n(4949);
        expect_out("R9 before 5 s", M_REQ | M_EO, M_REQ);
        wait_n(1);
        expect_out("R9 at 5 s shutdown", M_REQ | M_EO, M_EO);
        wait_n(200);
        expect_out("R9 same press no restart", M_REQ, 6'b000000);
        btn_in = 1'b1;
        wait_n(10);
        expect_out("R10 no spo when off", M_SPO | M_REQ, 6'b000000);

        // R7 on-time 0, R9 disabled, R10
        clear_sts(3'b010);
        expect_out("R6 eo cleared", M_EO, 6'b000000);
        write_ctl(3'd4, 1'b0, 2'd3, 2'd3, 2'd3, 1'b1, 1'b0);
        btn_in = 1'b0;
        wait_n(3);
        expect_out("R7 on-time 0 before", M_REQ, 6'b000000);
        wait_n(1);
        expect_out("R7 on-time 0 immediate", M_REQ, M_REQ);
        wait_n(6000);
        expect_out("R9 disabled keeps on", M_REQ | M_EO, M_REQ);
        btn_in = 1'b1;
        wait_n(10);
        expect_out("R10 no spo after waking press", M_SPO | M_REQ, M_REQ);
        btn_in = 1'b0;
        wait_n(20);
        btn_in = 1'b1;
        wait_n(10);
        expect_out("R10 short press sets spo", M_SPO | M_REQ, M_SPO | M_REQ);

        // shutdown with enable off, then R7 enable=0
        clear_sts(3'b100);
        expect_out("R6 spo cleared", M_SPO, 6'b000000);
        write_ctl(3'd4, 1'b0, 2'd3, 2'd3, 2'd0, 1'b0, 1'b0);
        btn_in = 1'b0;
        wait_n(5010);
        expect_out("R9 shutdown again", M_REQ | M_EO, M_EO);
        btn_in = 1'b1;
        wait_n(10);
        btn_in = 1'b0;
        wait_n(700);
        expect_out("R7 enable off no wake", M_REQ, 6'b000000);
        btn_in = 1'b1;
        wait_n(10);

        // R8 override
        write_ctl(3'd4, 1'b0, 2'd3, 2'd3, 2'd3, 1'b0, 1'b1);
        expect_out("R8 override forces request", M_REQ, M_REQ);
        write_ctl(3'd4, 1'b0, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0);
        expect_out("R8 override removed", M_REQ, 6'b000000);

        // R7 on-time code 2 = 100
        write_ctl(3'd4, 1'b0, 2'd3, 2'd2, 2'd3, 1'b1, 1'b0);
        btn_in = 1'b0;
        wait_n(103);
        expect_out("R7 on-time 100 not yet", M_REQ, 6'b000000);
        wait_n(1);
        expect_out("R7 on-time 100 reached", M_REQ, M_REQ);
        btn_in = 1'b1;
        wait_n(10);

        // R9 code 1 = 10 s
        clear_sts(3'b111);
        write_ctl(3'd4, 1'b0, 2'd3, 2'd2, 2'd1, 1'b1, 1'b0);
        btn_in = 1'b0;
        wait_n(10003);
        expect_out("R9 before 10 s", M_REQ | M_EO, M_REQ);
        wait_n(1);
        expect_out("R9 at 10 s", M_REQ | M_EO, M_EO);
        btn_in = 1'b1;
        wait_n(10);

        finish_run();
    end

endmodule